// File: doc/BRIEF.md
# PCIe Configuration Window Address Translator

This block maps a configuration-space request onto a memory-mapped configuration window. A request names a bus, a device/function number and a 12-bit register offset. The block adds the packed relative offset `(bus << 20) | (devfn << 12) | offset` to a 64-bit window base. It also decides whether the access may proceed at all.

Requests are filtered on enable state, alignment and topology. Only device/function 0 answers on the root bus. Buses below the root port are unreachable while the link is down. Each request gets a registered response one cycle later. The response carries an accept flag, a reject reason, the window address and the completion behaviour. An accepted write is forwarded. A rejected write is dropped. A rejected read completes with all-ones data.

A small write port programs a control register (enable and window size) and the two 32-bit halves of the base. The block reports a read-only capability bit and the last bus number implied by the programmed size.

Top module: `ecam_xlate`

## Requirements
- R1: After synchronous reset the window is disabled, the size field holds 12 (so `last_bus` reads 12), the base is zero and `rsp_valid` is low.
- R2: A request presented on a clock edge produces its response on that edge: `rsp_valid` is high in the following cycle. When accepted, `rsp_addr` equals base + ((bus << 20) | (devfn << 12) | offset).
- R3: While the enable bit is clear, every request is rejected with reason code 1 and `rsp_addr` is zero.
- R4: When `req_bus` equals `root_bus`, a request with a nonzero device/function is rejected with reason code 3. Device/function 0 on the root bus is accepted whatever the link state.
- R5: When `req_bus` differs from `root_bus` and `link_up` is low, the request is rejected with reason code 4.
- R6: A request whose offset has either of bits 1:0 set is rejected with reason code 2. The reason codes follow the priority disabled (1) > misaligned (2) > root device/function (3) > link down (4). An accepted request reports 0.
- R7: On any rejected request, `rsp_addr` is zero.
  - A rejected read drives `rsp_fill` to all ones and `rsp_write` low.
  - A rejected write keeps `rsp_write` low and `rsp_fill` zero.
  - An accepted write raises `rsp_write`.
  - An accepted read leaves `rsp_fill` zero.
- R8: A write with `cfg_sel` = 0 loads the enable from data bit 0 and the size from data bits 20:16. `last_bus` then shows the size zero-extended. All other data bits have no effect.
- R9: `cfg_sel` = 1 loads base bits 31:0 and `cfg_sel` = 2 loads base bits 63:32. A write with `cfg_sel` = 3 changes nothing.
- R10: A request sampled on the same edge as a register write is judged with the register values from before that write.
- R11: `cap_present` reflects the `PRESENT` parameter. When it is 0, writes to the enable bit are ignored and every request is rejected with reason code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 base low, 2 base high, 3 none |
| cfg_wdata | input | 32 | Register write data |
| cap_present | output | 1 | Read-only capability bit |
| last_bus | output | 8 | Last bus number implied by the size field |
| root_bus | input | 8 | Bus number of the root port |
| link_up | input | 1 | Link-up status |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request is a write |
| req_bus | input | 8 | Requested bus number |
| req_devfn | input | 8 | Requested device/function |
| req_off | input | 12 | Register offset in bytes |
| rsp_valid | output | 1 | Response strobe |
| rsp_accept | output | 1 | Access may proceed |
| rsp_reason | output | 3 | Reject reason code (0 none) |
| rsp_addr | output | 64 | Window address, zero when rejected |
| rsp_write | output | 1 | Accepted write to forward |
| rsp_fill | output | 32 | Completion data for a rejected read |

## Verification
A register write and a request can land on the same clock edge. The two cases that matter are clearing the enable while a request is presented, and rewriting the base low word while a request is presented. The bench drives both in one cycle. It judges the response against the old enable and old base. The following request must then see the new values. The interaction of link state with the root-bus rule is also covered: the root bus is moved away from bus 0, and the bench confirms that bus 0 becomes subject to the link check.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
    localparam int BUS_W      = 8;
    localparam int FN_W       = 8;
    localparam int OFF_W      = 12;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 2 * DATA_W;
    localparam int SIZE_W     = 5;
    localparam int SIZE_LSB   = 16;
    localparam int ALIGN_W    = 2;
    localparam int REL_W      = BUS_W + FN_W + OFF_W;
    localparam int REASON_W   = 3;

    typedef enum logic [REASON_W-1:0] {
        RSN_NONE       = 3'd0,
        RSN_DISABLED   = 3'd1,
        RSN_MISALIGNED = 3'd2,
        RSN_ROOT_FN    = 3'd3,
        RSN_LINK_DOWN  = 3'd4
    } reason_e;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_BASE_LO = 2'd1,
        SEL_BASE_HI = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                valid;
        logic                accept;
        reason_e             reason;
        logic                write;
        logic [DATA_W-1:0]   fill;
        logic [ADDR_W-1:0]   addr;
    } rsp_t;

    // Packed window-relative offset: bus above devfn above register offset.
    function automatic logic [REL_W-1:0] rel_offset(
        input logic [BUS_W-1:0] bus,
        input logic [FN_W-1:0]  devfn,
        input logic [OFF_W-1:0] off
    );
        return {bus, devfn, off};
    endfunction

    // Access decision, highest-priority rejection first.
    function automatic reason_e classify(
        input logic             en,
        input logic [BUS_W-1:0] root,
        input logic             link,
        input logic [BUS_W-1:0] bus,
        input logic [FN_W-1:0]  devfn,
        input logic [OFF_W-1:0] off
    );
        if (!en)                              return RSN_DISABLED;
        if (off[ALIGN_W-1:0] != '0)           return RSN_MISALIGNED;
        if (bus == root && devfn != '0)       return RSN_ROOT_FN;
        if (bus != root && !link)             return RSN_LINK_DOWN;
        return RSN_NONE;
    endfunction
endpackage

// File: rtl/ecam_regs.sv
module ecam_regs
    import ecam_pkg::*;
#(
    parameter bit PRESENT      = 1'b1,
    parameter int SIZE_DEFAULT = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [1:0]          sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic                enable,
    output logic [SIZE_W-1:0]   size,
    output logic [ADDR_W-1:0]   base
);
    localparam int HI_W = ADDR_W - DATA_W;

    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            size <= SIZE_W'(SIZE_DEFAULT);
            base <= '0;
        end else if (we) begin
            case (sel_e)
                SEL_CTRL:    size <= wdata[SIZE_LSB +: SIZE_W];
                SEL_BASE_LO: base[DATA_W-1:0] <= wdata;
                SEL_BASE_HI: base[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
                default:     ;
            endcase
        end
    end

    generate
        if (PRESENT) begin : g_present
            always_ff @(posedge clk) begin
                if (rst)                          enable <= 1'b0;
                else if (we && sel_e == SEL_CTRL) enable <= wdata[0];
            end

            a_r8_enable_load: assert property (@(posedge clk) disable iff (rst)
                (we && sel_e == SEL_CTRL) |=> (enable == $past(wdata[0])));
        end else begin : g_absent
            assign enable = 1'b0;
        end
    endgenerate

    a_r8_size_load: assert property (@(posedge clk) disable iff (rst)
        (we && sel_e == SEL_CTRL) |=> (size == $past(wdata[SIZE_LSB +: SIZE_W])));

    a_r9_base_lo_load: assert property (@(posedge clk) disable iff (rst)
        (we && sel_e == SEL_BASE_LO) |=> (base[DATA_W-1:0] == $past(wdata)));

    a_r9_none_sel_keeps_base: assert property (@(posedge clk) disable iff (rst)
        (we && sel_e == SEL_NONE) |=> $stable(base));
endmodule

// File: rtl/ecam_filter.sv
module ecam_filter
    import ecam_pkg::*;
(
    input  logic             enable,
    input  logic [BUS_W-1:0] root_bus,
    input  logic             link_up,
    input  logic [BUS_W-1:0] bus,
    input  logic [FN_W-1:0]  devfn,
    input  logic [OFF_W-1:0] off,
    output reason_e          reason,
    output logic             accept
);
    always_comb begin
        reason = classify(enable, root_bus, link_up, bus, devfn, off);
        accept = (reason == RSN_NONE);
    end
endmodule

// File: rtl/ecam_addr.sv
module ecam_addr
    import ecam_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [BUS_W-1:0]  bus,
    input  logic [FN_W-1:0]   devfn,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    assign addr = base + ADDR_W'(rel_offset(bus, devfn, off));
endmodule

// File: rtl/ecam_xlate.sv
module ecam_xlate
    import ecam_pkg::*;
#(
    parameter bit PRESENT      = 1'b1,
    parameter int SIZE_DEFAULT = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic                cap_present,
    output logic [BUS_W-1:0]    last_bus,
    input  logic [BUS_W-1:0]    root_bus,
    input  logic                link_up,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [BUS_W-1:0]    req_bus,
    input  logic [FN_W-1:0]     req_devfn,
    input  logic [OFF_W-1:0]    req_off,
    output logic                rsp_valid,
    output logic                rsp_accept,
    output logic [REASON_W-1:0] rsp_reason,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic                rsp_write,
    output logic [DATA_W-1:0]   rsp_fill
);
    logic              en;
    logic [SIZE_W-1:0] size;
    logic [ADDR_W-1:0] base;
    reason_e           reason;
    logic              accept;
    logic [ADDR_W-1:0] addr;
    rsp_t              rsp_q;

    ecam_regs #(.PRESENT(PRESENT), .SIZE_DEFAULT(SIZE_DEFAULT)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .enable(en), .size(size), .base(base)
    );

    ecam_filter u_filter (
        .enable(en), .root_bus(root_bus), .link_up(link_up),
        .bus(req_bus), .devfn(req_devfn), .off(req_off),
        .reason(reason), .accept(accept)
    );

    ecam_addr u_addr (
        .base(base), .bus(req_bus), .devfn(req_devfn), .off(req_off), .addr(addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '{valid: 1'b0, accept: 1'b0, reason: RSN_NONE, write: 1'b0,
                       fill: '0, addr: '0};
        end else begin
            rsp_q.valid  <= req_valid;
            rsp_q.accept <= req_valid && accept;
            rsp_q.reason <= req_valid ? reason : RSN_NONE;
            rsp_q.write  <= req_valid && accept && req_write;
            rsp_q.fill   <= (req_valid && !accept && !req_write) ? '1 : '0;
            rsp_q.addr   <= (req_valid && accept) ? addr : '0;
        end
    end

    assign cap_present = PRESENT;
    assign last_bus    = BUS_W'(size);
    assign rsp_valid   = rsp_q.valid;
    assign rsp_accept  = rsp_q.accept;
    assign rsp_reason  = rsp_q.reason;
    assign rsp_addr    = rsp_q.addr;
    assign rsp_write   = rsp_q.write;
    assign rsp_fill    = rsp_q.fill;

    a_r2_one_cycle_response: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r3_disabled_rejects: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !en) |=> (!rsp_accept && rsp_reason == RSN_DISABLED && rsp_addr == '0));

    a_r4_root_single_fn: assert property (@(posedge clk) disable iff (rst)
        (req_valid && en && req_bus == root_bus && req_devfn != '0 &&
         req_off[ALIGN_W-1:0] == '0) |=> (rsp_reason == RSN_ROOT_FN));

    a_r5_link_down_blocks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && en && req_bus != root_bus && !link_up &&
         req_off[ALIGN_W-1:0] == '0) |=> (rsp_reason == RSN_LINK_DOWN && !rsp_accept));

    a_r7_write_needs_accept: assert property (@(posedge clk) disable iff (rst)
        rsp_write |-> rsp_accept);

    a_r7_reject_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_accept) |-> (rsp_addr == '0));
endmodule

// File: tb/ecam_xlate_bench.sv
`timescale 1ns/1ps
module ecam_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  root_bus = 8'd0;
    logic        link_up = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_off = '0;

    logic        cap_present, rsp_valid, rsp_accept, rsp_write;
    logic [7:0]  last_bus;
    logic [2:0]  rsp_reason;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_fill;

    logic        np_cap, np_valid, np_accept, np_write;
    logic [7:0]  np_last;
    logic [2:0]  np_reason;
    logic [63:0] np_addr;
    logic [31:0] np_fill;

    int checks = 0;
    int errors = 0;
    logic [63:0] base_m = '0;

    always #10 clk = ~clk;

    ecam_xlate u_ecam_xlate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cap_present(cap_present), .last_bus(last_bus), .root_bus(root_bus),
        .link_up(link_up), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_reason(rsp_reason),
        .rsp_addr(rsp_addr), .rsp_write(rsp_write), .rsp_fill(rsp_fill)
    );

    ecam_xlate #(.PRESENT(1'b0)) u_ecam_xlate_np (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cap_present(np_cap), .last_bus(np_last), .root_bus(root_bus),
        .link_up(link_up), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
        .rsp_valid(np_valid), .rsp_accept(np_accept), .rsp_reason(np_reason),
        .rsp_addr(np_addr), .rsp_write(np_write), .rsp_fill(np_fill)
    );

    typedef struct packed {
        logic [7:0]  bus;
        logic [7:0]  fn;
        logic [11:0] off;
        logic        wr;
        logic        link;
        logic [2:0]  rsn;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{8'h00, 8'h00, 12'h000, 1'b0, 1'b0, 3'd0},
        '{8'h00, 8'h00, 12'hFFC, 1'b1, 1'b1, 3'd0},
        '{8'h00, 8'h01, 12'h000, 1'b0, 1'b1, 3'd3},
        '{8'h00, 8'hFF, 12'h010, 1'b1, 1'b1, 3'd3},
        '{8'h01, 8'h00, 12'h010, 1'b0, 1'b1, 3'd0},
        '{8'h01, 8'h00, 12'h010, 1'b0, 1'b0, 3'd4},
        '{8'hFF, 8'hFF, 12'hFFC, 1'b0, 1'b1, 3'd0},
        '{8'h02, 8'h0A, 12'h102, 1'b0, 1'b1, 3'd2},
        '{8'h00, 8'h03, 12'h001, 1'b1, 1'b0, 3'd2},
        '{8'h03, 8'h05, 12'h044, 1'b1, 1'b0, 3'd4}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_req(input logic [7:0] bus, input logic [7:0] fn,
                           input logic [11:0] off, input logic wr);
        req_valid = 1'b1; req_bus = bus; req_devfn = fn; req_off = off; req_write = wr;
    endtask

    task automatic send(input logic [7:0] bus, input logic [7:0] fn,
                        input logic [11:0] off, input logic wr);
        put_req(bus, fn, off, wr);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Judge one response against the requirement-level model.
    task automatic judge(input string tag, input logic [7:0] bus, input logic [7:0] fn,
                         input logic [11:0] off, input logic wr, input logic [2:0] rsn);
        logic ok;
        ok = (rsn == 3'd0);
        chk({tag, " valid"},  64'(rsp_valid), 64'd1);
        chk({tag, " accept"}, 64'(rsp_accept), 64'(ok));
        chk({tag, " reason"}, 64'(rsp_reason), 64'(rsn));
        chk({tag, " addr"},   rsp_addr, ok ? base_m + {36'd0, bus, fn, off} : 64'd0);
        chk({tag, " write"},  64'(rsp_write), 64'(ok && wr));
        chk({tag, " fill"},   64'(rsp_fill), (!ok && !wr) ? 64'hFFFF_FFFF : 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state, R11 capability bits
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 last_bus", 64'(last_bus), 64'd12);
        chk("R11 cap_present", 64'(cap_present), 64'd1);
        chk("R11 np cap_present", 64'(np_cap), 64'd0);

        // R3 disabled rejects; R6 disabled outranks misaligned and root fn
        link_up = 1'b1;
        send(8'h00, 8'h07, 12'h003, 1'b0);
        judge("R3 disabled", 8'h00, 8'h07, 12'h003, 1'b0, 3'd1);
        send(8'h04, 8'h00, 12'h000, 1'b1);
        judge("R3 disabled write", 8'h04, 8'h00, 12'h000, 1'b1, 3'd1);

        // R8 control fields, stray bits ignored
        cfg_write(2'd0, 32'h001F_0001);
        chk("R8 last_bus 31", 64'(last_bus), 64'd31);
        cfg_write(2'd0, 32'hFFE9_FFFF);
        chk("R8 last_bus masked", 64'(last_bus), 64'd9);

        // R9 base halves, select 3 inert
        cfg_write(2'd1, 32'hE000_0000);
        cfg_write(2'd2, 32'h0000_0012);
        base_m = 64'h0000_0012_E000_0000;
        cfg_write(2'd3, 32'hDEAD_BEEF);
        send(8'h00, 8'h00, 12'h000, 1'b0);
        judge("R9 base after sel3", 8'h00, 8'h00, 12'h000, 1'b0, 3'd0);

        // R2 R4 R5 R6 R7 table walk
        for (int i = 0; i < NVEC; i++) begin
            link_up = TBL[i].link;
            send(TBL[i].bus, TBL[i].fn, TBL[i].off, TBL[i].wr);
            judge($sformatf("R2/R4/R5/R6/R7 vec%0d", i), TBL[i].bus, TBL[i].fn,
                  TBL[i].off, TBL[i].wr, TBL[i].rsn);
        end

        // R4 R5 with root moved off bus 0
        root_bus = 8'h05; link_up = 1'b0;
        send(8'h05, 8'h01, 12'h000, 1'b0);
        judge("R4 root5 fn1", 8'h05, 8'h01, 12'h000, 1'b0, 3'd3);
        send(8'h05, 8'h00, 12'h020, 1'b1);
        judge("R4 root5 fn0 link down", 8'h05, 8'h00, 12'h020, 1'b1, 3'd0);
        send(8'h00, 8'h00, 12'h000, 1'b0);
        judge("R5 bus0 now downstream", 8'h00, 8'h00, 12'h000, 1'b0, 3'd4);
        root_bus = 8'h00; link_up = 1'b1;

        // R10 base write and request on the same edge: old base used
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h1000_0000;
        put_req(8'h01, 8'h02, 12'h008, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        judge("R10 old base", 8'h01, 8'h02, 12'h008, 1'b0, 3'd0);
        base_m = 64'h0000_0012_1000_0000;
        send(8'h01, 8'h02, 12'h008, 1'b0);
        judge("R10 new base", 8'h01, 8'h02, 12'h008, 1'b0, 3'd0);

        // R10 disable and request on the same edge: old enable used
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h000C_0000;
        put_req(8'h02, 8'h00, 12'h004, 1'b1);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        judge("R10 old enable", 8'h02, 8'h00, 12'h004, 1'b1, 3'd0);
        send(8'h02, 8'h00, 12'h004, 1'b1);
        judge("R10 now disabled", 8'h02, 8'h00, 12'h004, 1'b1, 3'd1);

        // R11 absent capability: enable write ignored
        cfg_write(2'd0, 32'h000C_0001);
        send(8'h00, 8'h00, 12'h000, 1'b0);
        chk("R11 present accepts", 64'(rsp_accept), 64'd1);
        chk("R11 absent accept", 64'(np_accept), 64'd0);
        chk("R11 absent reason", 64'(np_reason), 64'd1);
        chk("R11 absent fill", 64'(np_fill), 64'hFFFF_FFFF);

        // R1 reset again clears enable and size
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 last_bus after reset", 64'(last_bus), 64'd12);
        base_m = '0;
        send(8'h00, 8'h00, 12'h000, 1'b0);
        judge("R1 disabled after reset", 8'h00, 8'h00, 12'h000, 1'b0, 3'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule